// File: doc/BRIEF.md
# Quadword Store-Conditional Reservation Checker

This block decides whether a 16-byte conditional store may be written to memory. It keeps one reservation, left by an earlier load-and-reserve: a valid flag, a byte length and a real address. A conditional store request carries a base operand with its register selector, an index operand, a 128-bit register-pair value and the current summary-overflow bit. The block forms the effective address, compares it with the reservation, issues the memory write when the store may proceed, and returns a 4-bit condition result. Address translation is not modelled, so the real address is the effective address.

Success needs a live reservation whose length is 16 bytes and whose address equals the effective address. When the length or the address differs but both addresses lie in the same smallest real page, the outcome is implementation-defined. The parameter `SAME_PAGE_STORE` selects it: 0 suppresses the store and reports failure, and 1 writes and reports success. Every aligned conditional store consumes the reservation. A request whose effective address is not 16-byte aligned raises a fault, writes nothing and leaves the reservation in place.

The controller has two states. In `SC_IDLE` it accepts a request when `mem_ready_i` is high. The transition *store-accepted* goes to `SC_WRITE` when the accepted request is allowed to store. Failures and faults stay in `SC_IDLE`. In `SC_WRITE` the write strobe is held. The transition *write-taken* returns to `SC_IDLE` on a cycle with `mem_ready_i` high, and *write-held* stays in `SC_WRITE` otherwise.

Top module: `resv_sc_check`

## Requirements
- R1: The effective address is (selector == 0 ? 0 : base) + index, modulo 2^ADDR_W. It appears on `mem_addr_o` with every write.
- R2: With a valid reservation of length 16 at exactly the effective address, `mem_we_o` rises one cycle after acceptance. At that point `mem_addr_o` is the effective address, `mem_data_o` is the request data, and result bit 1 is 1.
- R3: The result `res_cr_o` has bits [3:2] = 0, bit 1 = success and bit 0 = the request's summary-overflow bit.
- R4: With no valid reservation, no write occurs and result bit 1 is 0.
- R5: A mismatch of length or address whose page numbers differ gives no write and result bit 1 = 0. The page number is the address bits at and above log2(PAGE_BYTES).
- R6: A mismatch of length or address with equal page numbers writes and succeeds when SAME_PAGE_STORE = 1. It gives no write and failure when SAME_PAGE_STORE = 0.
- R7: Every aligned conditional store clears the reservation, so a repeat store to the same address fails.
- R8: A reservation set in the same cycle as an accepted store is checked against the old reservation and survives the clear.
- R9: An effective address with a nonzero value in bits [3:0] sets `res_fault_o`, writes nothing, reports failure and keeps the reservation.
- R10: `res_valid_o` pulses for exactly the cycle after acceptance. No request is accepted while `mem_ready_i` is low. A pending write holds `mem_we_o` and `mem_addr_o` until `mem_ready_i` is high.
- R11: After reset there is no reservation, `mem_we_o`, `res_valid_o` and `res_cr_o` are 0, and `req_ready_o` follows `mem_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rsv_set_i | input | 1 | Record a new reservation |
| rsv_len_i | input | LEN_W | Reserved length in bytes |
| rsv_addr_i | input | ADDR_W | Reserved real address |
| req_valid_i | input | 1 | Conditional store request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_sel_i | input | SEL_W | Base register selector (0 means zero base) |
| req_base_i | input | ADDR_W | Base operand |
| req_index_i | input | ADDR_W | Index operand |
| req_data_i | input | DATA_W | Register-pair value to store |
| req_so_i | input | 1 | Summary-overflow bit |
| mem_ready_i | input | 1 | Memory port can take a write |
| mem_we_o | output | 1 | Write strobe |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | DATA_W | Write data |
| res_valid_o | output | 1 | Result valid pulse |
| res_cr_o | output | 4 | Condition result |
| res_fault_o | output | 1 | Alignment fault for this result |

## Verification
The bench builds two copies of the block with a 12-bit address and a 256-byte page, so that sixteen pages cover the whole address space. One copy uses SAME_PAGE_STORE = 0 and the other uses SAME_PAGE_STORE = 1. Both see the same stimulus. The small address space lets the bench try every aligned effective address against a fixed reservation, so every exact match, same-page mismatch and cross-page mismatch is seen under both policies.

// File: rtl/resv_sc_pkg.sv
package resv_sc_pkg;
    typedef enum logic [0:0] {
        SC_IDLE  = 1'b0,
        SC_WRITE = 1'b1
    } sc_state_e;

    typedef enum logic [1:0] {
        VERDICT_FAIL  = 2'd0,
        VERDICT_STORE = 2'd1,
        VERDICT_ALIGN = 2'd2
    } verdict_e;
endpackage

// File: rtl/resv_ea_calc.sv
module resv_ea_calc #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 5
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [ADDR_W-1:0] base_eff;

    always_comb begin
        base_eff = (sel_i == '0) ? '0 : base_i;
        ea_o     = base_eff + index_i;
    end
endmodule

// File: rtl/resv_holder.sv
module resv_holder #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              set_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            len_o   <= '0;
            addr_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            len_o   <= len_i;
            addr_o  <= addr_i;
        end else if (clr_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_judge.sv
module resv_judge
    import resv_sc_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LEN_W           = 5,
    parameter int QW_BYTES        = 16,
    parameter int ALIGN_LSB       = 4,
    parameter int PG_LSB          = 12,
    parameter bit SAME_PAGE_STORE = 1'b0
) (
    input  logic              rsv_valid_i,
    input  logic [LEN_W-1:0]  rsv_len_i,
    input  logic [ADDR_W-1:0] rsv_addr_i,
    input  logic [ADDR_W-1:0] ea_i,
    output verdict_e          verdict_o
);
    logic misaligned;
    logic exact_hit;
    logic same_page;
    logic page_ok;

    always_comb begin
        misaligned = (ea_i[ALIGN_LSB-1:0] != '0);
        exact_hit  = rsv_valid_i && (rsv_len_i == LEN_W'(QW_BYTES)) && (rsv_addr_i == ea_i);
        same_page  = rsv_valid_i && (rsv_addr_i[ADDR_W-1:PG_LSB] == ea_i[ADDR_W-1:PG_LSB]);
        page_ok    = SAME_PAGE_STORE && same_page;
        if (misaligned)
            verdict_o = VERDICT_ALIGN;
        else if (exact_hit || page_ok)
            verdict_o = VERDICT_STORE;
        else
            verdict_o = VERDICT_FAIL;
    end
endmodule

// File: rtl/resv_sc_check.sv
module resv_sc_check
    import resv_sc_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int DATA_W          = 128,
    parameter int SEL_W           = 5,
    parameter int LEN_W           = 5,
    parameter int PAGE_BYTES      = 4096,
    parameter bit SAME_PAGE_STORE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsv_set_i,
    input  logic [LEN_W-1:0]  rsv_len_i,
    input  logic [ADDR_W-1:0] rsv_addr_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [SEL_W-1:0]  req_sel_i,
    input  logic [ADDR_W-1:0] req_base_i,
    input  logic [ADDR_W-1:0] req_index_i,
    input  logic [DATA_W-1:0] req_data_i,
    input  logic              req_so_i,
    input  logic              mem_ready_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              res_valid_o,
    output logic [3:0]        res_cr_o,
    output logic              res_fault_o
);
    localparam int QW_BYTES  = DATA_W / 8;
    localparam int ALIGN_LSB = $clog2(QW_BYTES);
    localparam int PG_LSB    = $clog2(PAGE_BYTES);

    sc_state_e         state, state_nx;
    verdict_e          verdict;
    logic              accept;
    logic [ADDR_W-1:0] ea;
    logic              rsv_valid;
    logic [LEN_W-1:0]  rsv_len;
    logic [ADDR_W-1:0] rsv_addr;

    resv_ea_calc #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ea (
        .sel_i   (req_sel_i),
        .base_i  (req_base_i),
        .index_i (req_index_i),
        .ea_o    (ea)
    );

    resv_holder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept && (verdict != VERDICT_ALIGN)),
        .set_i   (rsv_set_i),
        .len_i   (rsv_len_i),
        .addr_i  (rsv_addr_i),
        .valid_o (rsv_valid),
        .len_o   (rsv_len),
        .addr_o  (rsv_addr)
    );

    resv_judge #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .QW_BYTES(QW_BYTES),
        .ALIGN_LSB(ALIGN_LSB), .PG_LSB(PG_LSB), .SAME_PAGE_STORE(SAME_PAGE_STORE)
    ) u_judge (
        .rsv_valid_i (rsv_valid),
        .rsv_len_i   (rsv_len),
        .rsv_addr_i  (rsv_addr),
        .ea_i        (ea),
        .verdict_o   (verdict)
    );

    assign req_ready_o = (state == SC_IDLE) && mem_ready_i;
    assign accept      = req_valid_i && req_ready_o;
    assign mem_we_o    = (state == SC_WRITE);

    always_comb begin
        state_nx = state;
        unique case (state)
            SC_IDLE:  if (accept && verdict == VERDICT_STORE) state_nx = SC_WRITE;
            SC_WRITE: if (mem_ready_i) state_nx = SC_IDLE;
            default:  state_nx = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            res_cr_o    <= '0;
            res_fault_o <= 1'b0;
            mem_addr_o  <= '0;
            mem_data_o  <= '0;
        end else begin
            res_valid_o <= accept;
            if (accept) begin
                res_cr_o    <= {2'b00, (verdict == VERDICT_STORE), req_so_i};
                res_fault_o <= (verdict == VERDICT_ALIGN);
                mem_addr_o  <= ea;
                mem_data_o  <= req_data_i;
            end
        end
    end
endmodule

// File: rtl/resv_sc_check_sva.sv
module resv_sc_check_sva #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mem_ready_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              res_valid_o,
    input logic [3:0]        res_cr_o,
    input logic              res_fault_o
);
    localparam int ALIGN_LSB = $clog2(DATA_W / 8);

    AST_CR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> res_cr_o[3:2] == 2'b00); // R3
    AST_WRITE_IS_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> (res_valid_o && res_cr_o[1])); // R2
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_fault_o) |-> (!mem_we_o && !res_cr_o[1])); // R9
    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_addr_o[ALIGN_LSB-1:0] == '0); // R9
    AST_RESULT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(req_valid_i && req_ready_o)); // R10
    AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready_i |-> !req_ready_o); // R10
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o))); // R10
endmodule

bind resv_sc_check resv_sc_check_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .mem_ready_i (mem_ready_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .res_valid_o (res_valid_o),
    .res_cr_o    (res_cr_o),
    .res_fault_o (res_fault_o)
);

// File: tb/resv_sc_check_test.sv
`timescale 1ns/1ps
module resv_sc_check_test;
    localparam int AW = 12;
    localparam int DW = 128;
    localparam int SW = 5;
    localparam int LW = 5;
    localparam int PG = 256;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          rsv_set = 1'b0;
    logic [LW-1:0] rsv_len = '0;
    logic [AW-1:0] rsv_addr = '0;
    logic          req_valid = 1'b0;
    logic [SW-1:0] req_sel = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_index = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_so = 1'b0;
    logic          mem_ready = 1'b1;

    logic          a_rdy, a_we, a_rv, a_flt;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_data;
    logic [3:0]    a_cr;
    logic          b_rdy, b_we, b_rv, b_flt;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_data;
    logic [3:0]    b_cr;

    int n_chk = 0;
    int n_bad = 0;

    resv_sc_check #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .LEN_W(LW),
                    .PAGE_BYTES(PG), .SAME_PAGE_STORE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .rsv_set_i(rsv_set), .rsv_len_i(rsv_len),
        .rsv_addr_i(rsv_addr), .req_valid_i(req_valid), .req_ready_o(a_rdy),
        .req_sel_i(req_sel), .req_base_i(req_base), .req_index_i(req_index),
        .req_data_i(req_data), .req_so_i(req_so), .mem_ready_i(mem_ready),
        .mem_we_o(a_we), .mem_addr_o(a_addr), .mem_data_o(a_data),
        .res_valid_o(a_rv), .res_cr_o(a_cr), .res_fault_o(a_flt));

    resv_sc_check #(.ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .LEN_W(LW),
                    .PAGE_BYTES(PG), .SAME_PAGE_STORE(1'b1)) uut_sp (
        .clk(clk), .rst_n(rst_n), .rsv_set_i(rsv_set), .rsv_len_i(rsv_len),
        .rsv_addr_i(rsv_addr), .req_valid_i(req_valid), .req_ready_o(b_rdy),
        .req_sel_i(req_sel), .req_base_i(req_base), .req_index_i(req_index),
        .req_data_i(req_data), .req_so_i(req_so), .mem_ready_i(mem_ready),
        .mem_we_o(b_we), .mem_addr_o(b_addr), .mem_data_o(b_data),
        .res_valid_o(b_rv), .res_cr_o(b_cr), .res_fault_o(b_flt));

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reserve(input logic [AW-1:0] a, input logic [LW-1:0] l);
        rsv_set = 1'b1; rsv_addr = a; rsv_len = l;
        @(negedge clk);
        rsv_set = 1'b0;
    endtask

    task automatic issue(input logic [SW-1:0] s, input logic [AW-1:0] b,
                         input logic [AW-1:0] x, input logic [DW-1:0] d, input logic so);
        while (!(a_rdy && b_rdy)) @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_base = b; req_index = x;
        req_data = d; req_so = so;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic issue_ea(input logic [AW-1:0] ea, input logic so);
        issue('0, AW'(12'hABC), ea, {4{32'hC0DE0000 | 32'(ea)}}, so);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] ra;
        ra = 12'h520;
        repeat (3) @(negedge clk);
        chk("R11 reset we", a_we, 0);
        chk("R11 reset rv", a_rv, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready", a_rdy, 1);
        chk("R11 cr", a_cr, 0);
        chk("R11 we", b_we, 0);

        // R4: no reservation yet
        issue_ea(ra, 1'b1);
        chk("R4 we uut", a_we, 0);
        chk("R4 we sp", b_we, 0);
        chk("R4 cr", a_cr, 4'b0001);
        chk("R10 rv", a_rv, 1);

        // Exact-match and page sweep (R1 R2 R3 R5 R6)
        for (int i = 0; i < (1 << AW) / 16; i++) begin
            logic [AW-1:0] ea, base, idx;
            logic [SW-1:0] s;
            logic [DW-1:0] d;
            logic ea_a, ea_b, so;
            ea   = AW'(i * 16);
            s    = SW'(i % 3);
            base = AW'(i * 53 + 7);
            idx  = ea - ((s != '0) ? base : '0);
            d    = {4{32'(i) ^ 32'h5A5A0000}};
            so   = i[0];
            @(negedge clk);
            reserve(ra, LW'(16));
            issue(s, base, idx, d, so);
            ea_a = (ea == ra);
            ea_b = ea_a || (ea[AW-1:8] == ra[AW-1:8]);
            chk("R2 R5 we uut", a_we, ea_a);
            chk("R6 we sp", b_we, ea_b);
            chk("R3 cr uut", a_cr, {2'b00, ea_a, so});
            chk("R3 R6 cr sp", b_cr, {2'b00, ea_b, so});
            if (ea_a) begin
                chk("R1 addr uut", a_addr, ea);
                chk("R2 data uut", a_data, d);
            end
            if (ea_b) chk("R1 R6 addr sp", b_addr, ea);
        end

        // Length mismatch (R6 R5)
        for (int i = 0; i < 32; i++) begin
            logic [AW-1:0] ea;
            ea = AW'(12'h400 + i * 16);
            @(negedge clk);
            reserve(ra, LW'(8));
            issue_ea(ea, 1'b0);
            chk("R6 len uut", a_we, 0);
            chk("R6 R5 len sp", b_we, (ea[AW-1:8] == ra[AW-1:8]));
        end

        // R7: reservation consumed
        @(negedge clk);
        reserve(ra, LW'(16));
        issue_ea(ra, 1'b0);
        chk("R7 first", a_cr, 4'b0010);
        issue_ea(ra, 1'b0);
        chk("R7 repeat uut", a_cr, 4'b0000);
        chk("R7 repeat sp", b_we, 0);

        // R8: set in same cycle as store
        @(negedge clk);
        reserve(ra, LW'(16));
        @(negedge clk);
        rsv_set = 1'b1; rsv_addr = 12'h300; rsv_len = LW'(16);
        issue_ea(ra, 1'b0);
        rsv_set = 1'b0;
        chk("R8 old used", a_we, 1);
        issue_ea(12'h300, 1'b0);
        chk("R8 new kept", a_we, 1);
        chk("R8 new addr", a_addr, 12'h300);

        // R9: misaligned
        @(negedge clk);
        reserve(ra, LW'(16));
        issue_ea(ra + 12'h4, 1'b1);
        chk("R9 fault", a_flt, 1);
        chk("R9 we uut", a_we, 0);
        chk("R9 we sp", b_we, 0);
        chk("R9 cr", a_cr, 4'b0001);
        issue_ea(ra, 1'b0);
        chk("R9 kept", a_we, 1);
        chk("R9 fault clr", a_flt, 0);

        // R10: stalls
        @(negedge clk);
        @(negedge clk);
        reserve(ra, LW'(16));
        mem_ready = 1'b0;
        req_valid = 1'b1; req_sel = '0; req_index = ra; req_data = '1; req_so = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 no accept rv", a_rv, 0);
            chk("R10 ready low", a_rdy, 0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 accepted rv", a_rv, 1);
        chk("R10 accepted we", a_we, 1);
        mem_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R10 we held", a_we, 1);
            chk("R10 addr held", a_addr, ra);
            chk("R10 rv pulse", a_rv, 0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R10 we done", a_we, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule